// File: doc/BRIEF.md
# Epoch-Based Backplane Transfer Allocator

The allocator decides, once per epoch, which source cards of a switched backplane may send to which destination cards. Each source card presents a row of destination requests, and each destination card can raise an inhibit bit when it cannot accept data. At the last cycle of every epoch the allocator captures the request matrix and the inhibit vector. During the following epoch it scans the matrix several positions per cycle and builds a conflict-free pairing. In this pairing a source is granted at most one destination, and a destination is granted to at most one source.

The scan has two passes. Sources marked as forwarding engines go first, and line-card sources go second. Within each pass, the order in which sources are visited and the order in which each source's destinations are tried are both rotated every epoch by offsets taken from a 16-bit LFSR. Low-numbered ports therefore get no standing advantage. The finished pairing is held on the grant outputs for the whole of the next epoch, so both cards can configure themselves before the transfer epoch. A 2-bit tag names the epoch whose requests are being shown. A new request set is accepted every epoch, so requests, scheduling and notification overlap in a pipeline.

Top module: `bpa_allocator`

## Requirements
- R1: `epoch_start` is high for exactly one cycle in every EPOCH_CYC cycles (default 8). The first cycle after reset is released is the first cycle of epoch 0.
- R2: In any cycle, no destination appears in the grant of more than one source.
- R3: Bit `s*NPORT+d` of `req_map` means source s asks for destination d. A source is granted only a destination it requested. Its grant is `grant_valid[s]`, and the destination is in `grant_dest[s*4 +: 4]`.
- R4: A destination whose `inhibit` bit is high in the capture cycle is granted to no source for that epoch.
- R5: Inputs are sampled in the last cycle of epoch E. The resulting grants are shown for all of epoch E+2, change only in cycles where `epoch_start` is high, and do not depend on the inputs of epoch E+1.
- R6: The pairing is maximal. A source left without a grant has every one of its requested, uninhibited destinations granted to some other source.
- R7: Sources whose bit in FE_MASK is set (default ports 0 and 1) are served before all other sources. Such a source never loses a requested, uninhibited destination to a line-card source.
- R8: Source scan order and destination try order rotate every epoch by offsets drawn from an LFSR (x^16+x^14+x^13+x^11+1, default seed 16'hACE1). Two line-card sources that contend for one destination each win it within 24 epochs.
- R9: `notify_tag` equals the epoch number, modulo 4, whose requests are being shown. It reads 2 in epoch 0 and 3 in epoch 1.
- R10: While reset is held and in epoch 0, `grant_valid` is all zero and `epoch_start` is high.
- R11: When every source requests a distinct destination and nothing is inhibited, all NPORT sources are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst | input | 1 | Synchronous active-high reset |
| req_map | input | NPORT*NPORT | Request matrix; row s at bits s*NPORT +: NPORT, bit d set asks for destination d |
| inhibit | input | NPORT | Destination inhibit, one bit per destination card |
| epoch_start | output | 1 | High in the first cycle of every epoch |
| grant_valid | output | NPORT | Source s holds a transfer grant |
| grant_dest | output | NPORT*DEST_W | Granted destination of source s at bits s*DEST_W +: DEST_W |
| notify_tag | output | 2 | Epoch number (mod 4) of the requests now granted |

## Verification
The checker assumes that `req_map` and `inhibit` are meaningful only in the cycle just before `epoch_start` rises, and it keeps its own delayed copy of that cycle's values to judge grants two epochs later. It also takes for granted that `notify_tag` advances only at epoch starts. The stimulus changes requests and inhibits only on the falling clock edge in the first cycle of an epoch, so every value has settled long before the capture cycle. The random epochs use sparse request rows and sparse inhibits, so contention, maximality and engine priority are all exercised.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int unsigned TAG_W = 2;
  typedef logic [TAG_W-1:0] tag_t;
  localparam int unsigned LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/bpa_epoch_timer.sv
module bpa_epoch_timer #(
  parameter int unsigned EPOCH_CYC = 8,
  parameter int unsigned PH_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PH_W-1:0]  phase,
  output logic             epoch_last,
  output logic             epoch_start,
  output bpa_pkg::tag_t    epoch_id
);
  logic [PH_W-1:0] phase_q;
  logic            start_q;
  bpa_pkg::tag_t   id_q;

  assign epoch_last  = (phase_q == PH_W'(EPOCH_CYC - 1));
  assign phase       = phase_q;
  assign epoch_start = start_q;
  assign epoch_id    = id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      start_q <= 1'b1;
      id_q    <= '0;
    end else begin
      phase_q <= epoch_last ? '0 : phase_q + PH_W'(1);
      start_q <= epoch_last;
      if (epoch_last) id_q <= id_q + bpa_pkg::TAG_W'(1);
    end
  end
endmodule

// File: rtl/bpa_shuffle_lfsr.sv
module bpa_shuffle_lfsr #(
  parameter int unsigned   NPORT = 15,
  parameter int unsigned   IW    = 4,
  parameter bpa_pkg::lfsr_t SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [IW-1:0] src_off,
  output logic [IW-1:0] dst_off
);
  bpa_pkg::lfsr_t state_q;
  logic           fb;

  assign fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
  assign src_off = IW'(int'(state_q[IW-1:0]) % NPORT);
  assign dst_off = IW'(int'(state_q[2*IW-1:IW]) % NPORT);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (step) state_q <= {state_q[14:0], fb};
  end
endmodule

// File: rtl/bpa_match_slice.sv
module bpa_match_slice #(
  parameter int unsigned NPORT = 15,
  parameter int unsigned IW    = 4
) (
  input  logic             en,
  input  logic [IW-1:0]    start,
  input  logic [NPORT-1:0] row,
  input  logic [NPORT-1:0] blocked,
  input  logic [NPORT-1:0] taken_in,
  output logic             hit,
  output logic [IW-1:0]    dst,
  output logic [NPORT-1:0] taken_out
);
  logic [NPORT-1:0] cand;
  int               idx;

  always_comb begin
    cand = row & ~blocked & ~taken_in;
    hit  = 1'b0;
    dst  = '0;
    idx  = 0;
    for (int i = 0; i < int'(NPORT); i++) begin
      idx = (int'(start) + i) % int'(NPORT);
      if (en && !hit && cand[idx]) begin
        hit = 1'b1;
        dst = IW'(idx);
      end
    end
    taken_out = taken_in;
    if (hit) taken_out[dst] = 1'b1;
  end
endmodule

// File: rtl/bpa_allocator.sv
module bpa_allocator #(
  parameter int unsigned      NPORT     = 15,
  parameter int unsigned      DEST_W    = $clog2(NPORT),
  parameter int unsigned      EPOCH_CYC = 8,
  parameter logic [NPORT-1:0] FE_MASK   = 15'h0003,
  parameter logic [15:0]      LFSR_SEED = 16'hACE1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT*NPORT-1:0]    req_map,
  input  logic [NPORT-1:0]          inhibit,
  output logic                      epoch_start,
  output logic [NPORT-1:0]          grant_valid,
  output logic [NPORT*DEST_W-1:0]   grant_dest,
  output logic [1:0]                notify_tag
);
  localparam int unsigned PH_W = (EPOCH_CYC > 1) ? $clog2(EPOCH_CYC) : 1;
  localparam int unsigned NPOS = 2 * NPORT;
  localparam int unsigned PAR  = (NPOS + EPOCH_CYC - 1) / EPOCH_CYC;
  localparam int unsigned PW   = $clog2(EPOCH_CYC * PAR + 1) + 1;

  logic [PH_W-1:0] phase;
  logic            epoch_last;
  bpa_pkg::tag_t   epoch_id;
  logic [DEST_W-1:0] src_off, dst_off;

  bpa_epoch_timer #(.EPOCH_CYC(EPOCH_CYC), .PH_W(PH_W)) u_timer (
    .clk(clk), .rst(rst), .phase(phase), .epoch_last(epoch_last),
    .epoch_start(epoch_start), .epoch_id(epoch_id)
  );

  bpa_shuffle_lfsr #(.NPORT(NPORT), .IW(DEST_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(epoch_last), .src_off(src_off), .dst_off(dst_off)
  );

  // Captured epoch state
  logic [NPORT-1:0][NPORT-1:0] ev_req;
  logic [NPORT-1:0]            ev_inh;
  logic [DEST_W-1:0]           ev_src_off, ev_dst_off;
  bpa_pkg::tag_t               ev_tag;

  // Working pairing built during evaluation
  logic [NPORT-1:0]              work_taken, work_valid;
  logic [NPORT-1:0][DEST_W-1:0]  work_dest;
  logic [NPORT-1:0]              nxt_valid;
  logic [NPORT-1:0][DEST_W-1:0]  nxt_dest;

  // Registered grant outputs
  logic [NPORT-1:0]              gv_q;
  logic [NPORT-1:0][DEST_W-1:0]  gd_q;
  bpa_pkg::tag_t                 tag_q;

  logic [PAR:0][NPORT-1:0]       taken_chain;
  logic [PAR-1:0]                slice_hit;
  logic [PAR-1:0][DEST_W-1:0]    slice_src;
  logic [PAR-1:0][DEST_W-1:0]    slice_dst;

  assign taken_chain[0] = work_taken;

  for (genvar g = 0; g < int'(PAR); g++) begin : g_slice
    logic [PW-1:0]     pos;
    logic              in_range, card_pass, en;
    logic [DEST_W-1:0] k, src;

    always_comb begin
      pos       = PW'(phase) * PW'(PAR) + PW'(g);
      in_range  = pos < PW'(NPOS);
      card_pass = pos >= PW'(NPORT);
      k         = card_pass ? DEST_W'(pos - PW'(NPORT)) : DEST_W'(pos);
      src       = DEST_W'((int'(k) + int'(ev_src_off)) % int'(NPORT));
      en        = in_range && (FE_MASK[src] != card_pass);
    end

    assign slice_src[g] = src;

    bpa_match_slice #(.NPORT(NPORT), .IW(DEST_W)) u_slice (
      .en(en), .start(ev_dst_off), .row(ev_req[src]), .blocked(ev_inh),
      .taken_in(taken_chain[g]), .hit(slice_hit[g]), .dst(slice_dst[g]),
      .taken_out(taken_chain[g+1])
    );
  end

  always_comb begin
    nxt_valid = work_valid;
    nxt_dest  = work_dest;
    for (int g = 0; g < int'(PAR); g++) begin
      if (slice_hit[g]) begin
        nxt_valid[slice_src[g]] = 1'b1;
        nxt_dest[slice_src[g]]  = slice_dst[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_req     <= '0;
      ev_inh     <= '0;
      ev_src_off <= '0;
      ev_dst_off <= '0;
      ev_tag     <= bpa_pkg::tag_t'(3);
      work_taken <= '0;
      work_valid <= '0;
      work_dest  <= '0;
      gv_q       <= '0;
      gd_q       <= '0;
      tag_q      <= bpa_pkg::tag_t'(2);
    end else if (epoch_last) begin
      gv_q       <= nxt_valid;
      gd_q       <= nxt_dest;
      tag_q      <= ev_tag;
      work_taken <= '0;
      work_valid <= '0;
      work_dest  <= '0;
      ev_req     <= req_map;
      ev_inh     <= inhibit;
      ev_src_off <= src_off;
      ev_dst_off <= dst_off;
      ev_tag     <= epoch_id;
    end else begin
      work_taken <= taken_chain[PAR];
      work_valid <= nxt_valid;
      work_dest  <= nxt_dest;
    end
  end

  assign grant_valid = gv_q;
  assign grant_dest  = gd_q;
  assign notify_tag  = tag_q;
endmodule

// File: rtl/bpa_allocator_chk.sv
module bpa_allocator_chk #(
  parameter int unsigned      NPORT     = 15,
  parameter int unsigned      DEST_W    = 4,
  parameter int unsigned      EPOCH_CYC = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORT*NPORT-1:0]  req_map,
  input logic [NPORT-1:0]        inhibit,
  input logic                    epoch_start,
  input logic [NPORT-1:0]        grant_valid,
  input logic [NPORT*DEST_W-1:0] grant_dest,
  input logic [1:0]              notify_tag
);
  logic [NPORT*NPORT-1:0] req_d, req_p;
  logic [NPORT-1:0]       inh_d, inh_p, used;
  logic                   started, dup, bad_req, bad_inh;
  logic [15:0]            gap;
  logic [DEST_W-1:0]      d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= '0; req_p <= '0; inh_d <= '0; inh_p <= '0;
      started <= 1'b0; gap <= '0;
    end else begin
      req_d <= req_map;
      inh_d <= inhibit;
      if (epoch_start) begin
        req_p   <= req_d;
        inh_p   <= inh_d;
        started <= 1'b1;
        gap     <= '0;
      end else begin
        gap <= gap + 16'd1;
      end
    end
  end

  always_comb begin
    dup = 1'b0; bad_req = 1'b0; bad_inh = 1'b0; used = '0; d = '0;
    for (int s = 0; s < int'(NPORT); s++) begin
      if (grant_valid[s]) begin
        d = grant_dest[s*DEST_W +: DEST_W];
        if (int'(d) >= int'(NPORT)) bad_req = 1'b1;
        else begin
          if (used[d]) dup = 1'b1;
          used[d] = 1'b1;
          if (!req_p[s*NPORT + int'(d)]) bad_req = 1'b1;
          if (inh_p[d]) bad_inh = 1'b1;
        end
      end
    end
  end

  assert_epoch_period_R1: assert property (@(posedge clk) disable iff (rst)
    (epoch_start && started) |-> (gap == 16'(EPOCH_CYC - 1)));
  assert_single_start_R1: assert property (@(posedge clk) disable iff (rst)
    epoch_start |=> !epoch_start);
  assert_unique_dest_R2: assert property (@(posedge clk) disable iff (rst) !dup);
  assert_requested_R3: assert property (@(posedge clk) disable iff (rst)
    epoch_start |-> !bad_req);
  assert_no_inhibited_R4: assert property (@(posedge clk) disable iff (rst)
    epoch_start |-> !bad_inh);
  assert_grant_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !epoch_start |-> ($stable(grant_valid) && $stable(grant_dest)));
  assert_tag_step_R9: assert property (@(posedge clk) disable iff (rst)
    (epoch_start && started) |-> (notify_tag == $past(notify_tag) + 2'd1));
endmodule

bind bpa_allocator bpa_allocator_chk #(
  .NPORT(NPORT), .DEST_W(DEST_W), .EPOCH_CYC(EPOCH_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_map(req_map), .inhibit(inhibit),
  .epoch_start(epoch_start), .grant_valid(grant_valid),
  .grant_dest(grant_dest), .notify_tag(notify_tag)
);

// File: tb/bpa_allocator_bench.sv
module bpa_allocator_bench;
  localparam int N  = 15;
  localparam int W  = 4;
  localparam int EC = 8;
  localparam logic [N-1:0] FE = 15'h0003;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N*N-1:0]   req_map = '0;
  logic [N-1:0]     inhibit = '0;
  logic             epoch_start;
  logic [N-1:0]     grant_valid;
  logic [N*W-1:0]   grant_dest;
  logic [1:0]       notify_tag;

  int checks = 0;
  int fails  = 0;
  int ep     = 0;
  bit done   = 1'b0;

  logic [N*N-1:0] rq_hist [32];
  logic [N-1:0]   ih_hist [32];

  always #5 clk = ~clk;

  bpa_allocator u_bpa_allocator (
    .clk(clk), .rst(rst), .req_map(req_map), .inhibit(inhibit),
    .epoch_start(epoch_start), .grant_valid(grant_valid),
    .grant_dest(grant_dest), .notify_tag(notify_tag)
  );

  task automatic report(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic next_epoch();
    @(negedge clk);
    while (!epoch_start) @(negedge clk);
    ep++;
  endtask

  task automatic present(input logic [N*N-1:0] rq, input logic [N-1:0] ih);
    req_map = rq;
    inhibit = ih;
  endtask

  function automatic logic [W-1:0] dest_of(input int s);
    return grant_dest[s*W +: W];
  endfunction

  task automatic verify(input logic [N*N-1:0] rq, input logic [N-1:0] ih);
    logic [N-1:0] used, by_card, avail;
    bit ok2, ok3, ok4, ok6, ok7;
    logic [W-1:0] d;
    used = '0; by_card = '0;
    ok2 = 1; ok3 = 1; ok4 = 1; ok6 = 1; ok7 = 1;
    for (int s = 0; s < N; s++) begin
      if (grant_valid[s]) begin
        d = dest_of(s);
        if (int'(d) >= N) ok3 = 0;
        else begin
          if (used[d]) ok2 = 0;
          used[d] = 1'b1;
          if (!FE[s]) by_card[d] = 1'b1;
          if (!rq[s*N + int'(d)]) ok3 = 0;
          if (ih[d]) ok4 = 0;
        end
      end
    end
    for (int s = 0; s < N; s++) begin
      if (!grant_valid[s]) begin
        avail = rq[s*N +: N] & ~ih;
        if ((avail & ~used) != '0) ok6 = 0;
        if (FE[s] && ((avail & by_card) != '0)) ok7 = 0;
      end
    end
    report(ok2, "R2", "destination used twice", 64'(grant_valid), 64'(used));
    report(ok3, "R3", "grant to unrequested destination", 64'(grant_valid), 64'(used));
    report(ok4, "R4", "grant to inhibited destination", 64'(used), 64'(used & ~ih));
    report(ok6, "R6", "pairing not maximal", 64'(grant_valid), 64'(used));
    report(ok7, "R7", "engine lost to line card", 64'(by_card), 64'(0));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    report(epoch_start == 1'b1, "R10", "epoch_start in reset", 64'(epoch_start), 64'(1));
    report(grant_valid == '0, "R10", "grants in reset", 64'(grant_valid), 64'(0));
    rst = 1'b0;
    ep  = 0;
    report(grant_valid == '0, "R10", "grants in epoch 0", 64'(grant_valid), 64'(0));
    report(notify_tag == 2'd2, "R9", "tag in epoch 0", 64'(notify_tag), 64'(2));
  endtask

  task automatic t_timing();
    int n;
    n = 0;
    @(negedge clk); n++;
    while (!epoch_start) begin @(negedge clk); n++; end
    ep++;
    report(n == EC, "R1", "epoch length", 64'(n), 64'(EC));
    report(notify_tag == 2'd3, "R9", "tag in epoch 1", 64'(notify_tag), 64'(3));
  endtask

  task automatic t_single();
    logic [N*N-1:0] rq;
    int e0;
    rq = '0;
    rq[7*N + 12] = 1'b1;
    next_epoch();
    e0 = ep;
    present(rq, '0);
    next_epoch();
    present('0, '0);
    report(grant_valid[7] == 1'b0, "R5", "grant one epoch early", 64'(grant_valid), 64'(0));
    next_epoch();
    report(grant_valid == (N'(1) << 7), "R3", "single grant vector", 64'(grant_valid), 64'(1) << 7);
    report(dest_of(7) == 4'd12, "R3", "single grant destination", 64'(dest_of(7)), 64'(12));
    report(notify_tag == 2'(e0), "R9", "tag of shown epoch", 64'(notify_tag), 64'(e0 % 4));
    repeat (5) @(negedge clk);
    report(grant_valid == (N'(1) << 7), "R5", "grant held within epoch", 64'(grant_valid), 64'(1) << 7);
  endtask

  task automatic t_inhibit();
    logic [N*N-1:0] rq;
    logic [N-1:0]   ih;
    rq = '0;
    rq[2*N + 6] = 1'b1; rq[5*N + 6] = 1'b1; rq[9*N + 6] = 1'b1;
    rq[4*N + 6] = 1'b1; rq[4*N + 8] = 1'b1;
    ih = '0; ih[6] = 1'b1;
    next_epoch();
    present(rq, ih);
    next_epoch();
    present('0, '0);
    next_epoch();
    report(grant_valid == (N'(1) << 4), "R4", "only uninhibited grant", 64'(grant_valid), 64'(1) << 4);
    report(dest_of(4) == 4'd8, "R4", "alternate destination", 64'(dest_of(4)), 64'(8));
  endtask

  task automatic t_priority();
    logic [N*N-1:0] rq;
    rq = '0;
    rq[0*N + 7] = 1'b1; rq[5*N + 7] = 1'b1; rq[10*N + 7] = 1'b1;
    next_epoch();
    present(rq, '0);
    next_epoch();
    for (int i = 0; i < 6; i++) begin
      next_epoch();
      report(grant_valid == N'(1) && dest_of(0) == 4'd7, "R7", "engine wins contended destination",
             64'(grant_valid), 64'(1));
    end
    present('0, '0);
  endtask

  task automatic t_full();
    logic [N*N-1:0] rq;
    bit ok;
    rq = '0;
    for (int s = 0; s < N; s++) rq[s*N + (s + 1) % N] = 1'b1;
    next_epoch();
    present(rq, '0);
    next_epoch();
    present('0, '0);
    next_epoch();
    report(grant_valid == {N{1'b1}}, "R11", "all sources granted", 64'(grant_valid), 64'({N{1'b1}}));
    ok = 1;
    for (int s = 0; s < N; s++) if (int'(dest_of(s)) != (s + 1) % N) ok = 0;
    report(ok, "R11", "full load destinations", 64'(grant_dest), 64'(0));
  endtask

  task automatic t_fair();
    logic [N*N-1:0] rq;
    int w3, w9;
    w3 = 0; w9 = 0;
    rq = '0;
    rq[3*N + 4] = 1'b1; rq[9*N + 4] = 1'b1;
    next_epoch();
    present(rq, '0);
    next_epoch();
    for (int i = 0; i < 24; i++) begin
      next_epoch();
      report(grant_valid[3] ^ grant_valid[9], "R8", "exactly one contender wins",
             64'(grant_valid), 64'(0));
      if (grant_valid[3]) w3++;
      if (grant_valid[9]) w9++;
    end
    present('0, '0);
    report(w3 > 0, "R8", "source 3 wins at least once", 64'(w3), 64'(1));
    report(w9 > 0, "R8", "source 9 wins at least once", 64'(w9), 64'(1));
  endtask

  task automatic t_random();
    logic [N*N-1:0] rq;
    logic [N-1:0]   ih;
    next_epoch();
    for (int i = 0; i < 30; i++) begin
      for (int s = 0; s < N; s++) rq[s*N +: N] = N'($urandom & $urandom);
      ih = N'($urandom & $urandom & $urandom);
      rq_hist[i] = rq;
      ih_hist[i] = ih;
      present(rq, ih);
      if (i >= 2) begin
        verify(rq_hist[i-2], ih_hist[i-2]);
        report(notify_tag == 2'(ep - 2), "R9", "pipelined tag", 64'(notify_tag), 64'((ep - 2) % 4));
      end
      next_epoch();
    end
    present('0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    t_reset();
    t_timing();
    t_single();
    t_inhibit();
    t_priority();
    t_full();
    t_fair();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule